// File: doc/BRIEF.md
# Half-Bridge Gate Guard with Drain-Source Fault Latching

This block drives the high-side and low-side gate enables of a set of half-bridges. Each bridge holds a 2-bit commanded mode that the host writes: one code turns the high-side switch on, one turns the low-side switch on, and the other two leave both switches off. Each switch also has a drain-source overvoltage comparator input. The block only watches that input while the switch is enabled. It ignores the input during a blanking window that opens at every turn-on edge. After the blanking window, the comparator must stay high for a filter time before it counts as a fault.

A confirmed fault sets a sticky status bit for that switch and masks both gates of the bridge. The commanded mode is left unchanged. The host may rewrite the mode while the bridge is masked, but the mask stays on. Only a write-1-to-clear of the bridge's status bits removes it. Once no status bit of the bridge is set, the gates again follow whatever mode is commanded at that time. A host that wants the bridge to stay off after recovery writes mode 00 before it clears the status.

Top module: `hbridge_guard`

## Requirements
- R1: After reset every mode reads 00, every gate enable is 0 and every status bit is 0.
- R2: With no status bit of bridge b set, mode 01 drives only the high-side enable, mode 10 drives only the low-side enable, and modes 00 and 11 drive neither. The enables follow a mode write from the clock edge that stores it.
- R3: The high-side and low-side enables of one bridge are never both 1.
- R4: A comparator input is ignored in the cycle in which its switch turns on and in the BLANK_CYC cycles that follow.
- R5: After blanking, a comparator input that is high for FILT_CYC consecutive cycles sets its status bit at the clock edge that ends the FILT_CYC-th cycle. A single low cycle restarts the count.
- R6: Status bit 2b belongs to the high side of bridge b and bit 2b+1 to its low side. While either bit of bridge b is set, both enables of bridge b are 0. Other bridges are not affected.
- R7: The mode register keeps its value through a fault and accepts new writes during a fault. No mode write re-enables a masked bridge.
- R8: Status bits are sticky and are cleared only by a 1 in the matching bit of the clear input. A 0 in the clear input leaves the bit unchanged. When the last set bit of a bridge clears, its enables resume the current mode on the next cycle.
- R9: If mode 00 is written before the clear, the bridge stays fully off after the clear.
- R10: A comparator input of a switch that is off never sets a status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr_i | input | NUM_BR | Per-bridge mode write strobe |
| mode_wdata_i | input | 2*NUM_BR | Mode data, bits [2b+1:2b] for bridge b |
| sts_clr_i | input | 2*NUM_BR | Write-1-to-clear strobes, one per switch |
| vds_hs_i | input | NUM_BR | High-side overvoltage comparator inputs |
| vds_ls_i | input | NUM_BR | Low-side overvoltage comparator inputs |
| hs_gate_o | output | NUM_BR | High-side gate enables |
| ls_gate_o | output | NUM_BR | Low-side gate enables |
| sts_o | output | 2*NUM_BR | Sticky fault status, bit 2b high side, 2b+1 low side |
| mode_o | output | 2*NUM_BR | Current commanded modes |

## Verification
A blanking counter that is off by one would show at the status output exactly one cycle early or late, relative to the edge computed from BLANK_CYC and FILT_CYC. The bench therefore samples the cycle before and the cycle of the expected fault. A filter count that fails to restart shows as a fault one cycle after the input's return, well before the full window. A fault that writes over the mode register, or a mask that does not clear, shows on the next cycle at mode_o or at the gate enables. The bench checks both after every write and every clear.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

    typedef enum logic [1:0] {
        BR_OFF   = 2'b00,
        BR_HIGH  = 2'b01,
        BR_LOW   = 2'b10,
        BR_PARK  = 2'b11
    } br_mode_t;

    localparam int unsigned SW_PER_BR = 2;
    localparam int unsigned SW_HIGH   = 0;
    localparam int unsigned SW_LOW    = 1;

    function automatic logic [SW_PER_BR-1:0] decode_mode(input br_mode_t m);
        logic [SW_PER_BR-1:0] en;
        en = '0;
        case (m)
            BR_HIGH: en[SW_HIGH] = 1'b1;
            BR_LOW:  en[SW_LOW]  = 1'b1;
            default: en = '0;
        endcase
        return en;
    endfunction

endpackage

// File: rtl/hbg_vds_qual.sv
module hbg_vds_qual #(
    parameter int unsigned BLANK_CYC = 8,
    parameter int unsigned FILT_CYC  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_en_i,
    input  logic vds_i,
    output logic confirm_o
);
    localparam int unsigned BW = $clog2(BLANK_CYC + 1) < 1 ? 1 : $clog2(BLANK_CYC + 1);
    localparam int unsigned FW = $clog2(FILT_CYC + 1) < 1 ? 1 : $clog2(FILT_CYC + 1);

    typedef struct packed {
        logic          was_on;
        logic [BW-1:0] blank;
        logic [FW-1:0] filt;
    } qual_t;

    qual_t q_d, q_q;
    logic  confirm;

    always_comb begin
        q_d        = q_q;
        confirm    = 1'b0;
        q_d.was_on = gate_en_i;
        if (!gate_en_i) begin
            q_d.blank = '0;
            q_d.filt  = '0;
        end else if (!q_q.was_on) begin
            q_d.blank = BW'(BLANK_CYC);
            q_d.filt  = '0;
        end else if (q_q.blank != '0) begin
            q_d.blank = q_q.blank - 1'b1;
            q_d.filt  = '0;
        end else if (vds_i) begin
            if (q_q.filt == FW'(FILT_CYC - 1)) begin
                confirm  = 1'b1;
                q_d.filt = '0;
            end else begin
                q_d.filt = q_q.filt + 1'b1;
            end
        end else begin
            q_d.filt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign confirm_o = confirm;

    assert_blank_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.blank != '0) |-> !confirm_o);

    assert_off_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_en_i |-> !confirm_o);

    assert_needs_input_R5: assert property (@(posedge clk) disable iff (!rst_n)
        confirm_o |-> vds_i);

endmodule

// File: rtl/hbg_bridge.sv
module hbg_bridge
    import hbg_pkg::*;
#(
    parameter int unsigned BLANK_CYC = 8,
    parameter int unsigned FILT_CYC  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_i,
    input  logic [1:0]           wdata_i,
    input  logic [SW_PER_BR-1:0] clr_i,
    input  logic [SW_PER_BR-1:0] vds_i,
    output logic [SW_PER_BR-1:0] gate_o,
    output logic [SW_PER_BR-1:0] sts_o,
    output logic [1:0]           mode_o
);
    typedef struct packed {
        br_mode_t             mode;
        logic [SW_PER_BR-1:0] sts;
    } br_t;

    br_t                  s_d, s_q;
    logic [SW_PER_BR-1:0] gate;
    logic [SW_PER_BR-1:0] confirm;

    always_comb begin
        gate = s_q.sts == '0 ? decode_mode(s_q.mode) : '0;
    end

    for (genvar sw = 0; sw < SW_PER_BR; sw++) begin : g_sw
        hbg_vds_qual #(
            .BLANK_CYC (BLANK_CYC),
            .FILT_CYC  (FILT_CYC)
        ) u_qual (
            .clk       (clk),
            .rst_n     (rst_n),
            .gate_en_i (gate[sw]),
            .vds_i     (vds_i[sw]),
            .confirm_o (confirm[sw])
        );

        assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (s_q.sts[sw] && !clr_i[sw]) |=> s_q.sts[sw]);
    end

    always_comb begin
        s_d     = s_q;
        s_d.sts = (s_q.sts & ~clr_i) | confirm;
        if (wr_i) s_d.mode = br_mode_t'(wdata_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.mode <= BR_OFF;
            s_q.sts  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign gate_o = gate;
    assign sts_o  = s_q.sts;
    assign mode_o = s_q.mode;

    assert_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_o[SW_HIGH] && gate_o[SW_LOW]));

    assert_fault_masks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_o != '0) |-> (gate_o == '0));

    assert_mode_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(mode_o));

endmodule

// File: rtl/hbridge_guard.sv
module hbridge_guard
    import hbg_pkg::*;
#(
    parameter int unsigned NUM_BR    = 3,
    parameter int unsigned BLANK_CYC = 8,
    parameter int unsigned FILT_CYC  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_BR-1:0]     mode_wr_i,
    input  logic [2*NUM_BR-1:0]   mode_wdata_i,
    input  logic [2*NUM_BR-1:0]   sts_clr_i,
    input  logic [NUM_BR-1:0]     vds_hs_i,
    input  logic [NUM_BR-1:0]     vds_ls_i,
    output logic [NUM_BR-1:0]     hs_gate_o,
    output logic [NUM_BR-1:0]     ls_gate_o,
    output logic [2*NUM_BR-1:0]   sts_o,
    output logic [2*NUM_BR-1:0]   mode_o
);
    for (genvar b = 0; b < NUM_BR; b++) begin : g_br
        logic [SW_PER_BR-1:0] gate;
        hbg_bridge #(
            .BLANK_CYC (BLANK_CYC),
            .FILT_CYC  (FILT_CYC)
        ) u_br (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_i    (mode_wr_i[b]),
            .wdata_i (mode_wdata_i[2*b +: 2]),
            .clr_i   (sts_clr_i[2*b +: 2]),
            .vds_i   ({vds_ls_i[b], vds_hs_i[b]}),
            .gate_o  (gate),
            .sts_o   (sts_o[2*b +: 2]),
            .mode_o  (mode_o[2*b +: 2])
        );
        assign hs_gate_o[b] = gate[SW_HIGH];
        assign ls_gate_o[b] = gate[SW_LOW];
    end

endmodule

// File: tb/hbridge_guard_tb.sv
module hbridge_guard_tb;
    localparam int NB = 3;
    localparam int B  = 8;
    localparam int F  = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NB-1:0]   mode_wr = '0;
    logic [2*NB-1:0] mode_wdata = '0;
    logic [2*NB-1:0] sts_clr = '0;
    logic [NB-1:0]   vds_hs = '0;
    logic [NB-1:0]   vds_ls = '0;
    logic [NB-1:0]   hs_gate, ls_gate;
    logic [2*NB-1:0] sts, mode;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    hbridge_guard #(.NUM_BR(NB), .BLANK_CYC(B), .FILT_CYC(F)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_wr_i    (mode_wr),
        .mode_wdata_i (mode_wdata),
        .sts_clr_i    (sts_clr),
        .vds_hs_i     (vds_hs),
        .vds_ls_i     (vds_ls),
        .hs_gate_o    (hs_gate),
        .ls_gate_o    (ls_gate),
        .sts_o        (sts),
        .mode_o       (mode)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_mode(input int b, input logic [1:0] m);
        mode_wr[b] = 1'b1;
        mode_wdata[2*b +: 2] = m;
        step(1);
        mode_wr[b] = 1'b0;
    endtask

    task automatic clear(input logic [2*NB-1:0] bits);
        sts_clr = bits;
        step(1);
        sts_clr = '0;
    endtask

    task automatic t_reset;
        chk("R1 mode", 32'(mode), 0);
        chk("R1 hs", 32'(hs_gate), 0);
        chk("R1 ls", 32'(ls_gate), 0);
        chk("R1 sts", 32'(sts), 0);
    endtask

    task automatic t_modes;
        wr_mode(0, 2'b01);
        chk("R2 01 hs", 32'(hs_gate[0]), 1);
        chk("R2 01 ls", 32'(ls_gate[0]), 0);
        wr_mode(0, 2'b10);
        chk("R2 10 hs", 32'(hs_gate[0]), 0);
        chk("R2 10 ls", 32'(ls_gate[0]), 1);
        chk("R3 not both", 32'(hs_gate[0] & ls_gate[0]), 0);
        wr_mode(0, 2'b11);
        chk("R2 11 off", 32'({hs_gate[0], ls_gate[0]}), 0);
        wr_mode(0, 2'b00);
        chk("R2 00 off", 32'({hs_gate[0], ls_gate[0]}), 0);
    endtask

    task automatic t_off_ignored;
        vds_hs[1] = 1'b1;
        vds_ls[1] = 1'b1;
        step(20);
        chk("R10 off switch no fault", 32'(sts), 0);
        vds_ls[1] = 1'b0;
    endtask

    task automatic t_blank_filter;
        // vds_hs[1] still high as the switch turns on
        wr_mode(1, 2'b01);
        step(B);
        vds_hs[1] = 1'b0;
        step(20);
        chk("R4 blanked input ignored", 32'(sts[3:2]), 0);
        chk("R4 still on", 32'(hs_gate[1]), 1);
        vds_hs[1] = 1'b1;
        step(F - 1);
        chk("R5 no fault before window", 32'(sts[3:2]), 0);
        step(1);
        chk("R5 fault at window end", 32'(sts[3:2]), 2'b01);
        chk("R6 hs masked", 32'(hs_gate[1]), 0);
        vds_hs[1] = 1'b0;
        clear(6'b00_01_00);
        chk("R8 cleared", 32'(sts[3:2]), 0);
        chk("R8 resumes mode", 32'(hs_gate[1]), 1);
        step(B + 2);
        vds_hs[1] = 1'b1;
        step(F - 1);
        vds_hs[1] = 1'b0;
        step(1);
        vds_hs[1] = 1'b1;
        step(F - 1);
        chk("R5 low cycle restarts count", 32'(sts[3:2]), 0);
        step(1);
        chk("R5 fault after restart", 32'(sts[3:2]), 2'b01);
        vds_hs[1] = 1'b0;
        wr_mode(1, 2'b00);
        clear(6'b00_01_00);
        chk("R9 off after clear", 32'({hs_gate[1], ls_gate[1]}), 0);
    endtask

    task automatic t_fault_hold;
        wr_mode(2, 2'b10);
        wr_mode(0, 2'b01);
        vds_hs[0] = 1'b1;
        step(B + F);
        chk("R4 R5 no fault yet", 32'(sts[1:0]), 0);
        chk("R2 hs on before fault", 32'(hs_gate[0]), 1);
        step(1);
        chk("R6 hs status bit", 32'(sts[1:0]), 2'b01);
        chk("R6 bridge off", 32'({hs_gate[0], ls_gate[0]}), 0);
        chk("R6 other bridge unaffected", 32'(ls_gate[2]), 1);
        chk("R7 mode kept", 32'(mode[1:0]), 2'b01);
        wr_mode(0, 2'b10);
        chk("R7 write accepted", 32'(mode[1:0]), 2'b10);
        chk("R7 write does not unmask", 32'({hs_gate[0], ls_gate[0]}), 0);
        wr_mode(0, 2'b01);
        clear(6'b00_00_10);
        chk("R8 zero bit no effect", 32'(sts[1:0]), 2'b01);
        chk("R8 still masked", 32'(hs_gate[0]), 0);
        vds_hs[0] = 1'b0;
        clear(6'b00_00_01);
        chk("R8 bit cleared", 32'(sts[1:0]), 0);
        chk("R8 resumes current mode", 32'(hs_gate[0]), 1);
    endtask

    task automatic t_ls_fault_park;
        vds_ls[2] = 1'b1;
        step(F - 1);
        chk("R5 ls no fault yet", 32'(sts[5:4]), 0);
        step(1);
        chk("R6 ls status bit", 32'(sts[5:4]), 2'b10);
        chk("R6 ls masked", 32'(ls_gate[2]), 0);
        chk("R6 bridge 0 unaffected", 32'(hs_gate[0]), 1);
        wr_mode(2, 2'b00);
        vds_ls[2] = 1'b0;
        clear(6'b10_00_00);
        chk("R9 sts cleared", 32'(sts[5:4]), 0);
        chk("R9 stays off", 32'({hs_gate[2], ls_gate[2]}), 0);
        step(2);
        chk("R9 still off", 32'({hs_gate[2], ls_gate[2]}), 0);
    endtask

    initial begin
        step(3);
        t_reset();
        rst_n = 1'b1;
        step(1);
        t_modes();
        t_off_ignored();
        t_blank_filter();
        t_fault_hold();
        t_ls_fault_park();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule